// File: doc/BRIEF.md
# Programmable DRAM Refresh Scheduler

This block decides when a DRAM controller should spend a cycle slot on a row refresh. A divider driven by a 6-bit frequency value produces one refresh obligation every 16 × (value + 1) clocks. Obligations are counted in a small pending counter, so an obligation that cannot be served at once is not lost. A row counter names the next row to refresh.

While an access is in progress, a pending refresh waits politely. Once an obligation has been waiting for at least 80 % of the refresh interval, it becomes urgent and is requested regardless of the active access, so that the access sequencer preempts the burst. When no access is active, a pending refresh is requested at once. The sequencer chooses the refresh style (CAS-before-RAS or RAS-only) and reports each completed refresh with a one-cycle done strobe.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `refresh_req` and `refresh_urgent` are 0 and `refresh_row` is 0.
- R2: With frequency value F, the first refresh obligation becomes visible on the outputs 16 × (F + 1) clocks after reset is released. Later obligations follow at the same spacing.
- R3: While at least one obligation is pending and `access_busy` is 0, `refresh_req` is 1.
- R4: While `access_busy` is 1 and the oldest obligation is not yet urgent, `refresh_req` is 0.
- R5: The age of the oldest obligation counts the clock cycles since it became pending, starting at 0. When the age reaches floor(0.8 × 16 × (F + 1)), `refresh_urgent` rises and `refresh_req` is 1 even with `access_busy` at 1.
- R6: A `refresh_done` pulse while an obligation is pending removes one obligation, advances `refresh_row` by one and restarts the age. `refresh_req` falls in the next cycle if no obligation remains.
- R7: A `refresh_done` pulse with nothing pending is ignored: `refresh_row` is unchanged and no request appears.
- R8: Up to 3 obligations are held. Further ticks saturate at 3, and each held obligation needs its own done pulse before `refresh_req` falls.
- R9: With size code S, the row counter wraps from 256 × 2^S − 1 to 0. For example, it wraps after 255 when S = 0, and holds 256 without wrapping when S = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freq_sel | input | 6 | Refresh frequency value F; interval is 16 × (F + 1) clocks |
| size_sel | input | 2 | DRAM size code S; 256 × 2^S rows |
| access_busy | input | 1 | An access or burst is currently active |
| refresh_done | input | 1 | One-cycle strobe: sequencer finished a refresh |
| refresh_req | output | 1 | Request for a refresh slot |
| refresh_urgent | output | 1 | Pending refresh has aged past the deadline; preempt |
| refresh_row | output | 11 | Row address for the next refresh |

## Verification
The hardest state to reach is a saturated backlog: several ticks must pass with no service so that the pending counter pins at its limit. The bench then has to drain it with back-to-back done pulses before the next tick arrives. The bench gets there by leaving a request unanswered for just over three intervals at the shortest setting, then pulsing done on consecutive cycles and watching the request stay high until the third pulse. Deadline preemption is reached by holding `access_busy` high from the cycle the request first shows. The bench counts cycles until the request comes back as urgent.

// File: rtl/refresh_sched_pkg.sv
// Package: shared helper functions for the refresh scheduler.
// Assumes intervals are small enough to fit a 32-bit int.
package refresh_sched_pkg;

    // Interval in clocks for a programmed frequency value.
    function automatic int span_of(input int freq, input int prescale);
        return prescale * (freq + 1);
    endfunction

    // Urgency threshold: integer part of num/den of the interval.
    function automatic int thresh_of(input int span, input int num, input int den);
        return (span * num) / den;
    endfunction

endpackage

// File: rtl/refresh_divider.sv
// Module: refresh_divider
// Counts down one refresh interval and pulses tick for one cycle at its end.
// Assumes span >= 1; reloads span-1 during reset and after every tick.
module refresh_divider #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W:0]   span,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;

    // Reload value is one less than the interval length.
    always_comb reload = CNT_W'(span - (CNT_W+1)'(1));

    // Down-counter that restarts on reset and on reaching zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= reload;
        else if (cnt_q == '0)  cnt_q <= reload;
        else                   cnt_q <= cnt_q - CNT_W'(1);
    end

    // Tick marks the last cycle of each interval.
    always_comb tick = (cnt_q == '0);
endmodule

// File: rtl/refresh_pending.sv
// Module: refresh_pending
// Holds the count of owed refreshes and the age of the oldest one, and
// flags urgency once the age reaches a fraction of the interval.
// Assumes done pulses are one cycle wide; the count saturates at its maximum.
module refresh_pending #(
    parameter int PEND_W = 2,
    parameter int CNT_W  = 10,
    parameter int NUM    = 4,
    parameter int DEN    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              done,
    input  logic [CNT_W:0]    span,
    output logic [PEND_W-1:0] pend_cnt,
    output logic              pending,
    output logic              served,
    output logic              urgent
);
    localparam int AGE_W = CNT_W + 1;
    localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};
    localparam logic [AGE_W-1:0]  AGE_MAX  = {AGE_W{1'b1}};

    logic [PEND_W-1:0] pend_q;
    logic [AGE_W-1:0]  age_q;
    int                thr;

    // A done pulse counts only when something is owed.
    always_comb served = done && (pend_q != '0);
    always_comb pending = (pend_q != '0);

    // Pending counter: saturating add on tick, subtract on service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            case ({tick, served})
                2'b10:   if (pend_q != PEND_MAX) pend_q <= pend_q + PEND_W'(1);
                2'b01:   pend_q <= pend_q - PEND_W'(1);
                default: pend_q <= pend_q;
            endcase
        end
    end

    // Age of the oldest obligation; restarts when idle or after service.
    always_ff @(posedge clk) begin
        if (!rst_n)                 age_q <= '0;
        else if (!pending || served) age_q <= '0;
        else if (age_q != AGE_MAX)  age_q <= age_q + AGE_W'(1);
    end

    // Deadline threshold and urgency flag.
    always_comb begin
        thr    = refresh_sched_pkg::thresh_of(int'(span), NUM, DEN);
        urgent = pending && (int'(age_q) >= thr);
    end

    assign pend_cnt = pend_q;
endmodule

// File: rtl/refresh_row_ctr.sv
// Module: refresh_row_ctr
// Row address counter that advances on each served refresh and wraps at
// the row count of the selected DRAM size.
// Assumes size_sel is held steady between resets.
module refresh_row_ctr #(
    parameter int SIZE_W   = 2,
    parameter int BASE_LOG = 8,
    parameter int ROW_W    = BASE_LOG + (1 << SIZE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [SIZE_W-1:0] size_sel,
    output logic [ROW_W-1:0]  row
);
    localparam int NSIZES = 1 << SIZE_W;

    logic [ROW_W-1:0] last_tab [NSIZES];
    logic [ROW_W-1:0] last_row;
    logic [ROW_W-1:0] row_q;

    // One last-row constant per size code.
    for (genvar s = 0; s < NSIZES; s++) begin : g_last
        assign last_tab[s] = ROW_W'((64'(1) << (BASE_LOG + s)) - 64'(1));
    end

    // Pick the wrap point for the current size.
    always_comb last_row = last_tab[size_sel];

    // Advance with wrap on each served refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)       row_q <= '0;
        else if (advance) row_q <= (row_q >= last_row) ? '0 : row_q + ROW_W'(1);
    end

    assign row = row_q;
endmodule

// File: rtl/refresh_sched.sv
// Module: refresh_sched (top)
// Refresh timer and arbiter: divides the clock into refresh intervals,
// tracks owed refreshes, defers to active accesses until the deadline and
// supplies the row to refresh. Assumes the sequencer answers a request with
// a one-cycle refresh_done strobe.
module refresh_sched #(
    parameter int FREQ_W   = 6,
    parameter int PRESCALE = 16,
    parameter int SIZE_W   = 2,
    parameter int BASE_LOG = 8,
    parameter int PEND_W   = 2,
    parameter int URG_NUM  = 4,
    parameter int URG_DEN  = 5,
    parameter int CNT_W    = $clog2(PRESCALE * (1 << FREQ_W)),
    parameter int ROW_W    = BASE_LOG + (1 << SIZE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREQ_W-1:0] freq_sel,
    input  logic [SIZE_W-1:0] size_sel,
    input  logic              access_busy,
    input  logic              refresh_done,
    output logic              refresh_req,
    output logic              refresh_urgent,
    output logic [ROW_W-1:0]  refresh_row
);
    logic [CNT_W:0]    span;
    logic              tick;
    logic [PEND_W-1:0] pend_cnt;
    logic              pending;
    logic              served;
    logic              urgent;

    // Interval length in clocks from the frequency value.
    always_comb span = (CNT_W+1)'(refresh_sched_pkg::span_of(int'(freq_sel), PRESCALE));

    refresh_divider #(.CNT_W(CNT_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .span  (span),
        .tick  (tick)
    );

    refresh_pending #(
        .PEND_W (PEND_W),
        .CNT_W  (CNT_W),
        .NUM    (URG_NUM),
        .DEN    (URG_DEN)
    ) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .done     (refresh_done),
        .span     (span),
        .pend_cnt (pend_cnt),
        .pending  (pending),
        .served   (served),
        .urgent   (urgent)
    );

    refresh_row_ctr #(
        .SIZE_W   (SIZE_W),
        .BASE_LOG (BASE_LOG),
        .ROW_W    (ROW_W)
    ) u_row (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (served),
        .size_sel (size_sel),
        .row      (refresh_row)
    );

    // Request when idle, or when the deadline forces preemption.
    always_comb refresh_req = pending && (!access_busy || urgent);
    always_comb refresh_urgent = urgent;
endmodule

// File: rtl/refresh_sched_chk.sv
// Module: refresh_sched_chk
// Temporal checks on the refresh scheduler, bound to every instance.
module refresh_sched_chk #(
    parameter int SIZE_W   = 2,
    parameter int BASE_LOG = 8,
    parameter int PEND_W   = 2,
    parameter int ROW_W    = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SIZE_W-1:0] size_sel,
    input logic              access_busy,
    input logic              refresh_done,
    input logic              refresh_req,
    input logic              refresh_urgent,
    input logic [ROW_W-1:0]  refresh_row,
    input logic [PEND_W-1:0] pend_cnt
);
    logic [ROW_W-1:0] last_row;
    always_comb last_row = ROW_W'((64'(1) << (BASE_LOG + int'(size_sel))) - 64'(1));

    // R5: urgency always produces a request.
    assert_urgent_forces_R5: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_urgent |-> refresh_req);

    // R4: a busy access blocks a non-urgent request.
    assert_defer_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (access_busy && !refresh_urgent) |-> !refresh_req);

    // R7: done with nothing owed leaves the row alone.
    assert_idle_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_done && pend_cnt == '0) |=> $stable(refresh_row));

    // R6: a served refresh steps the row by one below the wrap point.
    assert_row_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_done && pend_cnt != '0 && refresh_row < last_row && $stable(size_sel))
        |=> refresh_row == ROW_W'($past(refresh_row) + ROW_W'(1)));

    // R9: a served refresh at the last row wraps to zero.
    assert_row_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_done && pend_cnt != '0 && refresh_row == last_row && $stable(size_sel))
        |=> refresh_row == '0);
endmodule

bind refresh_sched refresh_sched_chk #(
    .SIZE_W   (SIZE_W),
    .BASE_LOG (BASE_LOG),
    .PEND_W   (PEND_W),
    .ROW_W    (ROW_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .size_sel       (size_sel),
    .access_busy    (access_busy),
    .refresh_done   (refresh_done),
    .refresh_req    (refresh_req),
    .refresh_urgent (refresh_urgent),
    .refresh_row    (refresh_row),
    .pend_cnt       (pend_cnt)
);

// File: tb/refresh_sched_tb.sv
// Directed bench for refresh_sched: one task per scenario.
module refresh_sched_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  freq_sel = '0;
    logic [1:0]  size_sel = '0;
    logic        access_busy = 1'b0;
    logic        refresh_done = 1'b0;
    logic        refresh_req;
    logic        refresh_urgent;
    logic [10:0] refresh_row;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    refresh_sched u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .freq_sel       (freq_sel),
        .size_sel       (size_sel),
        .access_busy    (access_busy),
        .refresh_done   (refresh_done),
        .refresh_req    (refresh_req),
        .refresh_urgent (refresh_urgent),
        .refresh_row    (refresh_row)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input int f, input int s);
        @(negedge clk);
        rst_n = 1'b0; freq_sel = 6'(f); size_sel = 2'(s);
        access_busy = 1'b0; refresh_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Advance negedges until req is seen; returns count of negedges waited.
    task automatic wait_req(output int waited);
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!refresh_req && waited < 5000);
    endtask

    task automatic serve_one();
        int w;
        wait_req(w);
        refresh_done = 1'b1;
        @(negedge clk);
        refresh_done = 1'b0;
    endtask

    // R1: reset state.
    task automatic t_reset();
        do_reset(0, 0);
        chk("R1 req in reset", int'(refresh_req), 0);
        @(negedge clk);
        chk("R1 req after release", int'(refresh_req), 0);
        chk("R1 urgent after release", int'(refresh_urgent), 0);
        chk("R1 row after release", int'(refresh_row), 0);
    endtask

    // R2, R3, R6: interval spacing, idle request, service drop.
    task automatic t_interval(input int f);
        int n = 16 * (f + 1);
        int w;
        int lowcnt = 0;
        do_reset(f, 0);
        wait_req(w);
        chk($sformatf("R2 first obligation f=%0d", f), w, n);
        chk("R3 req while idle", int'(refresh_req), 1);
        refresh_done = 1'b1;
        @(negedge clk);
        refresh_done = 1'b0;
        chk("R6 req drops after service", int'(refresh_req), 0);
        chk("R6 row advanced", int'(refresh_row), 1);
        w = 1;
        while (!refresh_req && w < 5000) begin
            @(negedge clk);
            w++;
        end
        chk($sformatf("R2 spacing f=%0d", f), w, n);
        lowcnt = lowcnt;
    endtask

    // R4, R5: deferral to a busy access, then forced preemption.
    task automatic t_defer();
        int f = 4;
        int thr = (16 * (f + 1) * 4) / 5;
        int w;
        int k = 0;
        int early = 0;
        do_reset(f, 0);
        wait_req(w);
        access_busy = 1'b1;
        do begin
            @(negedge clk);
            k++;
            if (!refresh_req && k == thr - 1) early = int'(refresh_urgent);
        end while (!refresh_req && k < 5000);
        chk("R4 held off while busy", k, thr);
        chk("R4 not urgent just before deadline", early, 0);
        chk("R5 urgent at deadline", int'(refresh_urgent), 1);
        refresh_done = 1'b1;
        @(negedge clk);
        refresh_done = 1'b0;
        chk("R5 urgent clears after service", int'(refresh_urgent), 0);
        access_busy = 1'b0;
    endtask

    // R7: done with nothing pending is ignored.
    task automatic t_idle_done();
        do_reset(0, 0);
        repeat (2) @(negedge clk);
        refresh_done = 1'b1;
        @(negedge clk);
        refresh_done = 1'b0;
        @(negedge clk);
        chk("R7 row unchanged", int'(refresh_row), 0);
        chk("R7 no request", int'(refresh_req), 0);
        serve_one();
        chk("R7 later service still counts", int'(refresh_row), 1);
    endtask

    // R8: backlog saturates at 3 and drains one per done.
    task automatic t_backlog();
        int w;
        do_reset(0, 0);
        wait_req(w);
        repeat (50) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            refresh_done = 1'b1;
            @(negedge clk);
            chk($sformatf("R8 req after done %0d", i + 1), int'(refresh_req), (i < 2) ? 1 : 0);
        end
        refresh_done = 1'b0;
        chk("R8 rows served", int'(refresh_row), 3);
    endtask

    // R9: row wrap per size code.
    task automatic t_wrap();
        do_reset(0, 0);
        for (int i = 0; i < 255; i++) serve_one();
        chk("R9 size0 last row", int'(refresh_row), 255);
        serve_one();
        chk("R9 size0 wrap", int'(refresh_row), 0);
        do_reset(0, 1);
        for (int i = 0; i < 256; i++) serve_one();
        chk("R9 size1 no wrap at 256", int'(refresh_row), 256);
        for (int i = 0; i < 256; i++) serve_one();
        chk("R9 size1 wrap", int'(refresh_row), 0);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_interval(0);
        t_interval(2);
        t_defer();
        t_idle_done();
        t_backlog();
        t_wrap();
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule